// File: doc/BRIEF.md
# Wait-State Host Register Port

This block is the host-facing register port of a serial bus controller. A host places an address on a 9-bit bus and raises a read or a write strobe. The block samples the request on its single clock and raises a wait signal in the next cycle. It keeps wait high until the access is finished, then returns read data or commits the write. Every host signal is sampled on the same clock edge as the rest of the core. No path is asynchronous.

The number of wait states depends on where the address points. The top address bit splits the map into two regions. The low half holds a small bank of control and status registers, which answer quickly. The high half holds data registers that stand in for a slower buffer path and take longer to read. Any address that maps to no register reads as zero, ignores writes and uses the fast timing.

The host drops its strobe one clock after it sees wait fall. The block therefore ignores strobes for one cycle after each access, so that a strobe still held high in that cycle does not start a second access.

Top module: `hostreg_port`

## Requirements
- R1: While reset (active high, synchronous) is asserted and after it is released, `hold` and `wr_done` are 0 and `rdata` is 0. All registers read as zero after reset.
- R2: Address bit 8 selects the region. With bit 8 = 0, offsets 0 to 3 are control/status registers. With bit 8 = 1, offsets 0 to 7 (addresses 0x100 to 0x107) are data registers. Each mapped register keeps the last 32-bit value written to it.
- R3: A read of a control/status register loads `rdata` at the first clock edge after the edge that samples the strobe. `hold` is high for exactly that one cycle.
- R4: A read of a data register loads `rdata` at the sixth clock edge after the sampling edge. `hold` is high for six cycles.
- R5: A write of any region completes at the second edge after the sampling edge. `wr_done` is high for exactly the one cycle that follows that edge, and the new value is readable afterwards.
- R6: `hold` rises in the cycle after the strobe is first sampled and stays high until the access completes.
- R7: A strobe that is still high in the cycle after `hold` falls starts no new access. `hold` stays low and `wr_done` does not pulse again.
- R8: If both strobes are high when an access starts, the block performs the write and ignores the read.
- R9: An unmapped address reads as zero and ignores writes. It uses the control/status timing: 1 cycle for a read and 2 cycles for a write, even when bit 8 is 1.
- R10: `rdata` changes only when a read completes. It keeps its value across writes and idle cycles.
- R11: The address, write data and strobe type are captured at the sampling edge. Changes on these inputs while `hold` is high have no effect on the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read request strobe |
| wr_stb | input | 1 | Write request strobe; takes priority over rd_stb |
| addr | input | 9 | Register address; bit 8 selects the region |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, held until the next read completes |
| hold | output | 1 | Wait: high while an access is in progress |
| wr_done | output | 1 | One-cycle pulse in the cycle a write takes effect |

## Verification
The assertions assume the host follows the handshake. Once a strobe has been sampled, the host keeps it high while `hold` is high and for exactly one cycle after `hold` falls. The host never begins a new request during that trailing cycle. The bench drives every access through a single task that follows this rule. The task also changes the address partway through one access to show that the captured copy is used.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    parameter int ADDR_W      = 9;
    parameter int DATA_W      = 32;
    parameter int CTRL_REGS   = 4;
    parameter int DATA_REGS   = 8;
    parameter int CTRL_RD_LAT = 1;
    parameter int DATA_RD_LAT = 6;
    parameter int WR_LAT      = 2;

    localparam int OFFS_W  = ADDR_W - 1;
    localparam int MAX_LAT = (DATA_RD_LAT > WR_LAT) ?
                             ((DATA_RD_LAT > CTRL_RD_LAT) ? DATA_RD_LAT : CTRL_RD_LAT) :
                             ((WR_LAT > CTRL_RD_LAT) ? WR_LAT : CTRL_RD_LAT);
    localparam int CNT_W   = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

    typedef enum logic [1:0] {
        RGN_CTRL = 2'd0,
        RGN_DATA = 2'd1,
        RGN_NONE = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_BUSY  = 2'd1,
        SQ_GUARD = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              is_write;
        region_e           rgn;
        logic [OFFS_W-1:0] offs;
        logic [DATA_W-1:0] wdata;
    } access_t;

    // Remaining cycles after the sampling edge, minus one, for the counter.
    function automatic logic [CNT_W-1:0] lat_load(input logic is_write, input region_e rgn);
        int lat;
        if (is_write)
            lat = WR_LAT;
        else if (rgn == RGN_DATA)
            lat = DATA_RD_LAT;
        else
            lat = CTRL_RD_LAT;
        return CNT_W'(lat - 1);
    endfunction

endpackage

// File: rtl/hrp_decode.sv
module hrp_decode
    import hrp_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           rgn,
    output logic [OFFS_W-1:0] offs
);

    localparam logic [OFFS_W-1:0] CTRL_LIM = OFFS_W'(CTRL_REGS);
    localparam logic [OFFS_W-1:0] DATA_LIM = OFFS_W'(DATA_REGS);

    always_comb begin
        offs = addr[OFFS_W-1:0];
        if (addr[ADDR_W-1])
            rgn = (offs < DATA_LIM) ? RGN_DATA : RGN_NONE;
        else
            rgn = (offs < CTRL_LIM) ? RGN_CTRL : RGN_NONE;
    end

endmodule

// File: rtl/hrp_sequencer.sv
module hrp_sequencer
    import hrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  region_e           rgn_in,
    input  logic [OFFS_W-1:0] offs_in,
    input  logic [DATA_W-1:0] wdata_in,
    output access_t           op_q,
    output logic              hold,
    output logic              complete,
    output logic              wr_done
);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             start;

    assign start    = (state == SQ_IDLE) && (rd_stb || wr_stb);
    assign hold     = (state == SQ_BUSY);
    assign complete = (state == SQ_BUSY) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            cnt     <= '0;
            op_q    <= '0;
            wr_done <= 1'b0;
        end else begin
            wr_done <= complete && op_q.is_write;
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        op_q.is_write <= wr_stb;
                        op_q.rgn      <= rgn_in;
                        op_q.offs     <= offs_in;
                        op_q.wdata    <= wdata_in;
                        cnt           <= lat_load(wr_stb, rgn_in);
                        state         <= SQ_BUSY;
                    end
                end
                SQ_BUSY: begin
                    if (cnt == '0)
                        state <= SQ_GUARD;
                    else
                        cnt <= cnt - 1'b1;
                end
                SQ_GUARD: state <= SQ_IDLE;
                default:  state <= SQ_IDLE;
            endcase
        end
    end

    // R6
    hold_rise_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> hold);

    // R3
    ctrl_read_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !wr_stb && rgn_in != RGN_DATA) |=> complete);

    // R5
    write_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (start && wr_stb) |=> !complete ##1 complete);

    // R5
    wr_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> !wr_done);

    // R7
    guard_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |=> !hold);

    // R8
    write_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (start && rd_stb && wr_stb) |=> op_q.is_write);

endmodule

// File: rtl/hrp_store.sv
module hrp_store
    import hrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  access_t           op,
    output logic [DATA_W-1:0] rd_val
);

    localparam int CIDX_W = (CTRL_REGS > 1) ? $clog2(CTRL_REGS) : 1;
    localparam int DIDX_W = (DATA_REGS > 1) ? $clog2(DATA_REGS) : 1;

    logic [DATA_W-1:0] ctrl_q [CTRL_REGS];
    logic [DATA_W-1:0] data_q [DATA_REGS];

    for (genvar gi = 0; gi < CTRL_REGS; gi++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst)
                ctrl_q[gi] <= '0;
            else if (we && op.rgn == RGN_CTRL && op.offs == OFFS_W'(gi))
                ctrl_q[gi] <= op.wdata;
        end
    end

    for (genvar gj = 0; gj < DATA_REGS; gj++) begin : g_data
        always_ff @(posedge clk) begin
            if (rst)
                data_q[gj] <= '0;
            else if (we && op.rgn == RGN_DATA && op.offs == OFFS_W'(gj))
                data_q[gj] <= op.wdata;
        end
    end

    always_comb begin
        unique case (op.rgn)
            RGN_CTRL: rd_val = ctrl_q[op.offs[CIDX_W-1:0]];
            RGN_DATA: rd_val = data_q[op.offs[DIDX_W-1:0]];
            default:  rd_val = '0;
        endcase
    end

endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              hold,
    output logic              wr_done
);

    region_e           dec_rgn;
    logic [OFFS_W-1:0] dec_offs;
    access_t           op_q;
    logic              complete;
    logic [DATA_W-1:0] store_val;
    logic              store_we;
    logic              rd_finish;

    hrp_decode u_decode (
        .addr (addr),
        .rgn  (dec_rgn),
        .offs (dec_offs)
    );

    hrp_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .rgn_in   (dec_rgn),
        .offs_in  (dec_offs),
        .wdata_in (wdata),
        .op_q     (op_q),
        .hold     (hold),
        .complete (complete),
        .wr_done  (wr_done)
    );

    assign store_we  = complete && op_q.is_write;
    assign rd_finish = complete && !op_q.is_write;

    hrp_store u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (store_we),
        .op     (op_q),
        .rd_val (store_val)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_finish)
            rdata <= store_val;
    end

    // R10
    rdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_finish |=> $stable(rdata));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_finish && op_q.rgn == RGN_NONE) |=> (rdata == '0));

endmodule

// File: tb/sim_hostreg_port.sv
module sim_hostreg_port;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_stb, wr_stb;
    logic [8:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        hold, wr_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hostreg_port u0 (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .rdata(rdata), .hold(hold), .wr_done(wr_done)
    );

    // kind: 0 read, 1 write, 2 both strobes
    typedef struct packed {
        logic [1:0]  kind;
        logic [8:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 9'h002, 32'hA5A5_0001, 32'h0,           4'd2},
        '{2'd0, 9'h002, 32'h0,         32'hA5A5_0001,   4'd1},
        '{2'd1, 9'h105, 32'hDEAD_BEEF, 32'h0,           4'd2},
        '{2'd0, 9'h105, 32'h0,         32'hDEAD_BEEF,   4'd6},
        '{2'd0, 9'h000, 32'h0,         32'h0,           4'd1},
        '{2'd1, 9'h040, 32'h0000_1234, 32'h0,           4'd2},
        '{2'd0, 9'h040, 32'h0,         32'h0,           4'd1},
        '{2'd1, 9'h1F0, 32'h0000_5555, 32'h0,           4'd2},
        '{2'd0, 9'h1F0, 32'h0,         32'h0,           4'd1},
        '{2'd2, 9'h003, 32'h0BAD_F00D, 32'h0,           4'd2},
        '{2'd0, 9'h003, 32'h0,         32'h0BAD_F00D,   4'd1},
        '{2'd0, 9'h107, 32'h0,         32'h0,           4'd6},
        '{2'd1, 9'h000, 32'hFFFF_FFFF, 32'h0,           4'd2},
        '{2'd0, 9'h000, 32'h0,         32'hFFFF_FFFF,   4'd1},
        '{2'd0, 9'h004, 32'h0,         32'h0,           4'd1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one access following the host rule; returns measured latency,
    // hold after the sampling edge, wr_done at completion, and guard result.
    task automatic run_acc(input logic [1:0] kind, input logic [8:0] a, input logic [31:0] d,
                           input bit move_addr,
                           output int lat, output logic h1, output logic wd, output logic guard_ok);
        int edges;
        @(negedge clk);
        rd_stb = (kind != 2'd1);
        wr_stb = (kind != 2'd0);
        addr   = a;
        wdata  = d;
        edges  = 0;
        h1     = 1'b0;
        forever begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (edges == 1) begin
                h1 = hold;
                if (move_addr) begin
                    addr  = a ^ 9'h001;
                    wdata = ~d;
                end
            end
            if (!hold || edges > 20) break;
        end
        lat = edges - 1;
        wd  = wr_done;
        @(posedge clk);
        @(negedge clk);
        guard_ok = !hold && !wr_done;
        rd_stb = 1'b0;
        wr_stb = 1'b0;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        logic h1, wd, gok;
        logic [31:0] prev;
        rst = 1'b1; rd_stb = 1'b0; wr_stb = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        chk(hold == 1'b0 && wr_done == 1'b0, "R1 hold/wr_done in reset", {30'b0, hold, wr_done}, 32'h0);
        chk(rdata == 32'h0, "R1 rdata in reset", rdata, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(hold == 1'b0 && rdata == 32'h0, "R1 after release", rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            prev = rdata;
            run_acc(VEC[i].kind, VEC[i].a, VEC[i].d, 1'b0, lat, h1, wd, gok);
            chk(h1 == 1'b1, $sformatf("R6 hold rise vec%0d", i), {31'b0, h1}, 32'h1);
            if (VEC[i].kind == 2'd0) begin
                chk(lat == int'(VEC[i].lat),
                    $sformatf("%s latency vec%0d", (VEC[i].lat == 4'd6) ? "R4" : "R3/R9", i),
                    32'(lat), 32'(VEC[i].lat));
                chk(rdata == VEC[i].exp, $sformatf("R2/R9 read data vec%0d", i), rdata, VEC[i].exp);
                chk(wd == 1'b0, $sformatf("R5 no wr_done on read vec%0d", i), {31'b0, wd}, 32'h0);
            end else begin
                chk(lat == int'(VEC[i].lat), $sformatf("R5 write latency vec%0d", i), 32'(lat), 32'(VEC[i].lat));
                chk(wd == 1'b1, $sformatf("R5 wr_done vec%0d", i), {31'b0, wd}, 32'h1);
                chk(rdata == prev, $sformatf("R10 rdata kept over write vec%0d", i), rdata, prev);
                if (VEC[i].kind == 2'd2)
                    chk(rdata == prev, "R8 read ignored when both strobes", rdata, prev);
            end
            chk(gok == 1'b1, $sformatf("R7 trailing strobe ignored vec%0d", i), {31'b0, gok}, 32'h1);
        end

        // R11: inputs change during hold; captured address/data must be used
        run_acc(2'd1, 9'h101, 32'h1357_9BDF, 1'b1, lat, h1, wd, gok);
        run_acc(2'd0, 9'h101, 32'h0, 1'b1, lat, h1, wd, gok);
        chk(rdata == 32'h1357_9BDF, "R11 captured access", rdata, 32'h1357_9BDF);
        chk(lat == 6, "R4 data read latency after move", 32'(lat), 32'd6);
        run_acc(2'd0, 9'h100, 32'h0, 1'b0, lat, h1, wd, gok);
        chk(rdata == 32'h0, "R11 neighbour untouched", rdata, 32'h0);

        // R10: idle cycles leave rdata alone
        prev = rdata;
        repeat (5) @(negedge clk);
        chk(rdata == prev && hold == 1'b0, "R10 idle stability", rdata, prev);

        // R1: reset in the middle of a data read clears everything
        @(negedge clk);
        rd_stb = 1'b1; addr = 9'h105;
        repeat (3) @(negedge clk);
        rst = 1'b1; rd_stb = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(hold == 1'b0 && rdata == 32'h0, "R1 mid-access reset", rdata, 32'h0);
        run_acc(2'd0, 9'h105, 32'h0, 1'b0, lat, h1, wd, gok);
        chk(rdata == 32'h0, "R1 registers cleared by reset", rdata, 32'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule